// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Sequencer

This block drives a two-wiper digital potentiometer while the serial bus is in step mode. The bus front end raises a one-cycle arm pulse once the step instruction byte has been acknowledged, and it passes the pot-select bit from that instruction. From then on, the block reads the bus as an unframed stream of step commands. Each clock pulse on the serial clock line moves the selected wiper by one tap. The level of the data line during the high phase sets the direction: high steps toward the upper end, low steps toward the lower end. No byte boundaries and no acknowledge slots exist in this stream.

The session ends on a STOP or a START condition, and neither produces a step. A START also raises a one-cycle restart pulse so that the front end returns to address reception. The block receives the present wiper codes from the register executor. It withholds any strobe that would push a code past its limit, so the codes saturate at the ends and never wrap. The inputs are serial clock and data levels that have already been synchronised to the system clock.

Top module: `wiper_stepper`

## Requirements
- R1: After reset, and at any time when no session is armed, the block keeps `active_o` low and issues no step strobe for any bus pulse.
- R2: During a session, a serial clock pulse with the data line high during its high phase produces exactly one `step_up_o` strobe. The strobe lasts one cycle and appears in the system cycle after the falling edge is seen. `step_pot_o` names the selected wiper.
- R3: During a session, a serial clock pulse with the data line low produces exactly one `step_dn_o` strobe, with the same timing as in R2.
- R4: A session takes any number of mixed up and down pulses with no acknowledge slots. The ninth and later pulses step just like the first eight.
- R5: The wiper index is latched from `pot_sel_i` at the arm pulse. Later changes of `pot_sel_i`, and further arm pulses during the session, do not change which wiper steps.
- R6: When the selected wiper code is 63 (all ones), an up pulse produces no strobe.
- R7: When the selected wiper code is 0, a down pulse produces no strobe.
- R8: A STOP (data rising while the serial clock is high) ends the session with no step. Pulses that follow produce no strobes.
- R9: A START (data falling while the serial clock is high) during a session ends it with no step. It gives a one-cycle `restart_o` pulse in the cycle after detection.
- R10: `step_up_o` and `step_dn_o` are never high in the same cycle.
- R11: If the arm pulse arrives while the serial clock is already high, the falling edge of that pulse produces no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_s | input | 1 | Synchronised serial clock level |
| sda_s | input | 1 | Synchronised serial data level |
| arm_i | input | 1 | One-cycle pulse: step instruction acknowledged |
| pot_sel_i | input | POT_W (1) | Wiper select bit taken from the instruction |
| wiper_codes_i | input | NUM_POTS*CODE_W (12) | Current wiper codes; wiper i in bits [i*CODE_W +: CODE_W] |
| step_up_o | output | 1 | One-cycle increment strobe to the executor |
| step_dn_o | output | 1 | One-cycle decrement strobe to the executor |
| step_pot_o | output | POT_W (1) | Wiper addressed by the last strobe |
| active_o | output | 1 | Step session in progress |
| restart_o | output | 1 | One-cycle pulse: START ended the session |

## Verification
Several rules are checked on every cycle by assertions: the two strobes are never high together, no strobe passes a saturated code, every strobe follows a falling clock edge seen during a session, and START or STOP clears the session in the next cycle. Other behaviour can only be shown by the bench scenarios. These cover the exact strobe cycle, the arithmetic result of long mixed pulse trains, the latching of the wiper select against later changes, the silence after STOP, and the pulse that was already high when the session was armed. A sweep over every starting code on both wipers shows the saturation ends in arithmetic form.

// File: rtl/wstep_pkg.sv
`timescale 1ns/1ps
package wstep_pkg;
   typedef enum logic [1:0] {
      STEP_NONE = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10
   } step_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/wstep_edge.sv
`timescale 1ns/1ps
module wstep_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q;
   logic sda_q;

   // An idle bus sits high, so the history registers reset high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      scl_rise_o = scl_s & ~scl_q;
      scl_fall_o = ~scl_s & scl_q;
      start_o    = scl_s & scl_q & sda_q & ~sda_s;
      stop_o     = scl_s & scl_q & ~sda_q & sda_s;
   end

   assert_edges_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({scl_rise_o, scl_fall_o, start_o, stop_o}) <= 1);
endmodule

// File: rtl/wstep_ctrl.sv
`timescale 1ns/1ps
module wstep_ctrl #(
   parameter int unsigned POT_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             sda_s,
   input  logic             arm_i,
   input  logic [POT_W-1:0] pot_sel_i,
   output logic             active_o,
   output logic             restart_o,
   output logic             commit_o,
   output logic             dir_up_o,
   output logic [POT_W-1:0] pot_o
);
   logic             active_q;
   logic             pulse_q;
   logic             dir_q;
   logic             restart_q;
   logic [POT_W-1:0] pot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         pulse_q   <= 1'b0;
         dir_q     <= 1'b0;
         restart_q <= 1'b0;
         pot_q     <= '0;
      end else begin
         restart_q <= 1'b0;
         if (active_q) begin
            if (start_i || stop_i) begin
               active_q  <= 1'b0;
               pulse_q   <= 1'b0;
               restart_q <= start_i;
            end else if (scl_rise_i) begin
               // Only a high phase that begins inside the session may step.
               pulse_q <= 1'b1;
               dir_q   <= sda_s;
            end else if (scl_fall_i) begin
               pulse_q <= 1'b0;
            end
         end else if (arm_i) begin
            active_q <= 1'b1;
            pulse_q  <= 1'b0;
            pot_q    <= pot_sel_i;
         end
      end
   end

   always_comb begin
      commit_o  = active_q & pulse_q & scl_fall_i;
      dir_up_o  = dir_q;
      pot_o     = pot_q;
      active_o  = active_q;
      restart_o = restart_q;
   end

   assert_start_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && start_i) |=> (!active_q && restart_q));
   assert_stop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && stop_i) |=> (!active_q && !restart_q));
   assert_pot_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> $stable(pot_q));
endmodule

// File: rtl/wstep_gate.sv
`timescale 1ns/1ps
module wstep_gate
   import wstep_pkg::*;
#(
   parameter int unsigned NUM_POTS = 2,
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned POT_W    = 1,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       commit_i,
   input  logic                       dir_up_i,
   input  logic [POT_W-1:0]           pot_i,
   input  logic [NUM_POTS*CODE_W-1:0] codes_i,
   output logic                       step_up_o,
   output logic                       step_dn_o,
   output logic [POT_W-1:0]           step_pot_o
);
   localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

   logic [NUM_POTS-1:0] at_top;
   logic [NUM_POTS-1:0] at_bot;
   step_kind_e          kind;

   generate
      if (SATURATE) begin : g_sat
         for (genvar i = 0; i < NUM_POTS; i++) begin : g_lim
            assign at_top[i] = (codes_i[i*CODE_W +: CODE_W] == CODE_TOP);
            assign at_bot[i] = (codes_i[i*CODE_W +: CODE_W] == '0);
         end
      end else begin : g_wrap
         assign at_top = '0;
         assign at_bot = '0;
      end
   endgenerate

   always_comb begin
      kind = STEP_NONE;
      if (commit_i) begin
         if (dir_up_i && !at_top[pot_i])      kind = STEP_INC;
         else if (!dir_up_i && !at_bot[pot_i]) kind = STEP_DEC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_up_o  <= 1'b0;
         step_dn_o  <= 1'b0;
         step_pot_o <= '0;
      end else begin
         step_up_o <= (kind == STEP_INC);
         step_dn_o <= (kind == STEP_DEC);
         if (kind != STEP_NONE) step_pot_o <= pot_i;
      end
   end

   assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up_o && step_dn_o));

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
            step_up_o |-> ($past(codes_i[pot_i*CODE_W +: CODE_W]) != CODE_TOP));
         assert_no_wrap_bot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            step_dn_o |-> ($past(codes_i[pot_i*CODE_W +: CODE_W]) != '0));
      end
   endgenerate
endmodule

// File: rtl/wiper_stepper.sv
`timescale 1ns/1ps
module wiper_stepper #(
   parameter int unsigned NUM_POTS = 2,
   parameter int unsigned CODE_W   = 6,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned POT_W   = wstep_pkg::idx_width(NUM_POTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_s,
   input  logic                       sda_s,
   input  logic                       arm_i,
   input  logic [POT_W-1:0]           pot_sel_i,
   input  logic [NUM_POTS*CODE_W-1:0] wiper_codes_i,
   output logic                       step_up_o,
   output logic                       step_dn_o,
   output logic [POT_W-1:0]           step_pot_o,
   output logic                       active_o,
   output logic                       restart_o
);
   generate
      if (NUM_POTS < 1) begin : g_bad_pots
         $error("wiper_stepper: NUM_POTS must be at least 1");
      end
      if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code
         $error("wiper_stepper: CODE_W must lie in 1..16");
      end
   endgenerate

   logic scl_rise;
   logic scl_fall;
   logic start_det;
   logic stop_det;
   logic commit;
   logic dir_up;
   logic [POT_W-1:0] pot_cur;

   wstep_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   wstep_ctrl #(.POT_W(POT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_det),
      .stop_i     (stop_det),
      .sda_s      (sda_s),
      .arm_i      (arm_i),
      .pot_sel_i  (pot_sel_i),
      .active_o   (active_o),
      .restart_o  (restart_o),
      .commit_o   (commit),
      .dir_up_o   (dir_up),
      .pot_o      (pot_cur)
   );

   wstep_gate #(
      .NUM_POTS (NUM_POTS),
      .CODE_W   (CODE_W),
      .POT_W    (POT_W),
      .SATURATE (SATURATE)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .dir_up_i   (dir_up),
      .pot_i      (pot_cur),
      .codes_i    (wiper_codes_i),
      .step_up_o  (step_up_o),
      .step_dn_o  (step_dn_o),
      .step_pot_o (step_pot_o)
   );

   assert_step_in_session_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up_o || step_dn_o) |-> ($past(active_o) && $past(scl_fall)));
endmodule

// File: tb/wiper_stepper_tb_top.sv
`timescale 1ns/1ps
module wiper_stepper_tb_top;
   localparam int NP = 2;
   localparam int CW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic arm = 1'b0;
   logic [0:0] psel = 1'b0;
   logic [CW-1:0] mdl [NP];
   logic preset_en = 1'b0;
   logic [0:0] preset_pot = 1'b0;
   logic [CW-1:0] preset_val = '0;
   logic up_o, dn_o, act_o, rst_pulse;
   logic [0:0] spot_o;
   int n_chk = 0;
   int n_fail = 0;
   int up_cnt = 0;
   int dn_cnt = 0;
   int rs_cnt = 0;

   always #2.5 clk = ~clk;

   wiper_stepper #(.NUM_POTS(NP), .CODE_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_s(scl), .sda_s(sda),
      .arm_i(arm), .pot_sel_i(psel),
      .wiper_codes_i({mdl[1], mdl[0]}),
      .step_up_o(up_o), .step_dn_o(dn_o), .step_pot_o(spot_o),
      .active_o(act_o), .restart_o(rst_pulse)
   );

   // Executor model: applies every strobe with plain modular arithmetic.
   always @(posedge clk) begin
      if (preset_en) mdl[preset_pot] <= preset_val;
      else if (up_o) mdl[spot_o] <= mdl[spot_o] + 1'b1;
      else if (dn_o) mdl[spot_o] <= mdl[spot_o] - 1'b1;
      if (up_o) up_cnt <= up_cnt + 1;
      if (dn_o) dn_cnt <= dn_cnt + 1;
      if (rst_pulse) rs_cnt <= rs_cnt + 1;
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic preset(input int p, input int v);
      preset_pot = 1'(p); preset_val = CW'(v); preset_en = 1'b1;
      idle(1);
      preset_en = 1'b0;
      idle(1);
   endtask

   task automatic do_arm(input int p);
      arm = 1'b1; psel = 1'(p);
      idle(1);
      arm = 1'b0;
      idle(1);
   endtask

   task automatic pulse(input logic dir, output logic u, output logic d, output logic [0:0] p);
      scl = 1'b0; idle(2);
      sda = dir; idle(2);
      scl = 1'b1; idle(3);
      scl = 1'b0; idle(1);
      u = up_o; d = dn_o; p = spot_o;
      idle(2);
   endtask

   task automatic stop_seq();
      scl = 1'b0; idle(1);
      sda = 1'b0; idle(2);
      scl = 1'b1; idle(2);
      sda = 1'b1; idle(3);
   endtask

   task automatic start_seq();
      scl = 1'b0; idle(1);
      sda = 1'b1; idle(2);
      scl = 1'b1; idle(2);
      sda = 1'b0; idle(3);
      scl = 1'b0; idle(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic u, d;
      logic [0:0] p;
      int e, ue, de, u0, d0, r0;
      mdl[0] = '0; mdl[1] = '0;
      idle(3);
      chk(act_o == 0 && up_o == 0 && dn_o == 0 && rst_pulse == 0, "R1 reset",
          {act_o, up_o, dn_o, rst_pulse}, 0);
      rst_n = 1'b1;
      idle(2);

      // R1: pulses without arming do nothing
      preset(0, 30);
      pulse(1'b1, u, d, p);
      pulse(1'b0, u, d, p);
      chk(mdl[0] == 30 && act_o == 0, "R1 idle pulses", int'(mdl[0]), 30);

      // R2 / R3: single steps and their timing cycle
      do_arm(0);
      chk(act_o == 1, "R2 armed", act_o, 1);
      pulse(1'b1, u, d, p);
      chk(u == 1 && d == 0 && p == 0, "R2 up strobe", {u, d, p}, 3'b100);
      chk(mdl[0] == 31, "R2 code after up", int'(mdl[0]), 31);
      pulse(1'b0, u, d, p);
      chk(u == 0 && d == 1, "R3 down strobe", {u, d}, 2'b01);
      chk(mdl[0] == 30, "R3 code after down", int'(mdl[0]), 30);

      // R4: long mixed train, no acknowledge slots
      u0 = up_cnt; d0 = dn_cnt; e = 30; ue = 0; de = 0;
      for (int k = 0; k < 40; k++) begin
         logic dir;
         dir = ((k * 5) % 7) < 4;
         pulse(dir, u, d, p);
         if (dir) begin e++; ue++; end else begin e--; de++; end
      end
      chk(int'(mdl[0]) == e, "R4 mixed code", int'(mdl[0]), e);
      chk(up_cnt - u0 == ue && dn_cnt - d0 == de, "R4 strobe counts", up_cnt - u0, ue);

      // R5: select latched at arm
      e = int'(mdl[0]);
      psel = 1'b1;
      do_arm(1);
      pulse(1'b1, u, d, p);
      chk(p == 0 && int'(mdl[0]) == e + 1 && mdl[1] == 0, "R5 pot held", int'(p), 0);
      stop_seq();

      // R8: STOP ends session without step
      chk(act_o == 0 && int'(mdl[0]) == e + 1, "R8 stop exit", act_o, 0);
      pulse(1'b1, u, d, p);
      chk(u == 0 && int'(mdl[0]) == e + 1, "R8 silent after stop", u, 0);

      // R9: START ends session with restart pulse
      do_arm(0);
      e = int'(mdl[0]); r0 = rs_cnt;
      start_seq();
      chk(act_o == 0 && rs_cnt - r0 == 1 && int'(mdl[0]) == e, "R9 start exit", rs_cnt - r0, 1);
      pulse(1'b0, u, d, p);
      chk(d == 0 && int'(mdl[0]) == e, "R9 silent after start", d, 0);

      // R11: armed while clock already high
      scl = 1'b0; idle(1);
      sda = 1'b1; idle(2);
      scl = 1'b1; idle(2);
      do_arm(0);
      scl = 1'b0; idle(1);
      chk(up_o == 0 && dn_o == 0, "R11 no step on open pulse", up_o, 0);
      idle(2);
      chk(int'(mdl[0]) == e && act_o == 1, "R11 code kept", int'(mdl[0]), e);
      pulse(1'b1, u, d, p);
      chk(u == 1, "R11 next pulse steps", u, 1);
      stop_seq();

      // R6: climb past the top on wiper 1
      preset(1, 58);
      do_arm(1);
      u0 = up_cnt;
      for (int k = 0; k < 10; k++) pulse(1'b1, u, d, p);
      chk(mdl[1] == 63 && up_cnt - u0 == 5, "R6 saturate top", int'(mdl[1]), 63);
      // R7: descend past zero
      preset(1, 3);
      d0 = dn_cnt;
      for (int k = 0; k < 10; k++) pulse(1'b0, u, d, p);
      chk(mdl[1] == 0 && dn_cnt - d0 == 3, "R7 saturate bottom", int'(mdl[1]), 0);
      stop_seq();

      // Sweep every starting code on both wipers (R2 R3 R6 R7 R10)
      for (int pp = 0; pp < NP; pp++) begin
         for (int s = 0; s < 64; s++) begin
            int e1, e2;
            preset(pp, s);
            do_arm(pp);
            e1 = (s < 63) ? s + 1 : 63;
            pulse(1'b1, u, d, p);
            chk(u == (s < 63) && d == 0, "R6 sweep up strobe", u, int'(s < 63));
            chk(int'(mdl[pp]) == e1, "R2 sweep up code", int'(mdl[pp]), e1);
            e2 = (e1 > 0) ? e1 - 1 : 0;
            pulse(1'b0, u, d, p);
            chk(d == (e1 > 0) && u == 0, "R10 sweep down strobe", d, int'(e1 > 0));
            chk(int'(mdl[pp]) == e2, "R3 sweep down code", int'(mdl[pp]), e2);
            if (s == 0) begin
               pulse(1'b0, u, d, p);
               chk(d == 0 && mdl[pp] == 0, "R7 sweep floor", d, 0);
            end
            stop_seq();
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule